// File: doc/BRIEF.md
# Security Tag Propagation Unit

This block runs beside a processor pipeline and, for every retired instruction, derives the security tags that the instruction leaves behind. A tag is a 3-bit level with an 8-bit compartment mask. The block joins the tags of the operands, the instruction and the program counter into a result tag, and it raises the program counter tag whenever a branch condition carries sensitive data. A private stack saves the program counter tag at each conditional branch. The tag is restored from that stack when the two paths of the branch meet again, so taint picked up from control flow lasts only as long as the code that depends on it.

Each instruction may also request one flow check:
- a read of a datum by the current principal;
- a write of a datum to an output channel;
- a load from an input channel.

A check that is not allowed by the lattice raises a trap with its own cause code. The trap blocks the result-tag write, leaves the program counter tag as it was and leaves the stack untouched. All outputs are registered and appear one cycle after a valid input. The processor returns `pc_tag_out` as `pc_tag_in` for the next instruction.

Top module: `sectag_unit`

## Requirements
- R1: For a plain instruction (`iclass`=0) that does not trap, `res_tag` is the join of `op_a_tag`, `op_b_tag`, `pc_tag_in` and `insn_tag`, and `res_we` is 1.
- R2: For a plain instruction that does not trap, `pc_tag_out` is the join of `pc_tag_in` and `insn_tag`.
- R3: For an unconditional branch (`iclass`=1) that does not trap, `pc_tag_out` is the join of `pc_tag_in` and `insn_tag`. `res_we` is 0 and the stack is unchanged.
- R4: For a conditional branch (`iclass`=2) that does not trap, `pc_tag_out` is the join of `op_a_tag` (the condition), `pc_tag_in` and `insn_tag`. The value of `pc_tag_in` is pushed onto the stack.
- R5: For a rejoin (`iclass`=3) that does not trap, the stack is popped and `pc_tag_out` equals the most recently pushed entry, in last-in first-out order.
- R6: A tag holds its level in bits [10:8] and its compartment mask in bits [7:0]. The join takes the larger level and the bitwise OR of the masks. Flow from X to Y is allowed when level(X) ≤ level(Y) and mask(X) is a subset of mask(Y).
- R7: With `chk_kind`=1 (read), the unit traps with cause 1 unless flow from `op_a_tag` to `principal_tag` is allowed.
- R8: With `chk_kind`=2 (output write), the unit traps with cause 2 unless flow from `op_a_tag` (the datum) to `op_b_tag` (the channel) is allowed.
- R9: With `chk_kind`=3 (input load), the unit traps with cause 3 unless flow from `op_a_tag` (the channel) to `principal_tag` is allowed. `chk_kind`=0 never traps.
- R10: A conditional branch while the 8-entry stack is full traps with cause 4. `pc_tag_out` equals `pc_tag_in` and the stack is unchanged.
- R11: A rejoin while the stack is empty traps with cause 5, and `pc_tag_out` equals `pc_tag_in`.
- R12: Outputs are registered one cycle after `in_valid`, and `out_valid` follows `in_valid` by one cycle. A trap forces `res_we` to 0 and leaves the stack unchanged. `trap_cause` is 0 exactly when no trap is signalled. A stack fault takes priority over a flow fault. After reset `out_valid`, `trap` and `res_we` are 0 and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction retires this cycle |
| iclass | input | 2 | 0 plain, 1 unconditional branch, 2 conditional branch, 3 rejoin |
| chk_kind | input | 2 | 0 none, 1 read, 2 output write, 3 input load |
| op_a_tag | input | 11 | Tag of operand A (condition, datum or input channel) |
| op_b_tag | input | 11 | Tag of operand B (or output channel) |
| insn_tag | input | 11 | Tag of the instruction word |
| pc_tag_in | input | 11 | Current program counter tag |
| principal_tag | input | 11 | Label of the running principal |
| out_valid | output | 1 | Outputs below belong to the previous valid input |
| res_tag | output | 11 | Result tag |
| res_we | output | 1 | Result tag write enable |
| pc_tag_out | output | 11 | Updated program counter tag |
| trap | output | 1 | Policy or stack violation |
| trap_cause | output | 3 | 0 none, 1 read, 2 output, 3 input, 4 stack overflow, 5 stack underflow |

## Verification
The join logic is tried with operand tags whose levels and masks differ, so a bench can tell a maximum from a sum and an OR from an AND. Nested branch and rejoin runs show whether the stack pops in last-in first-out order. These runs also show the stack filling exactly at eight entries and draining to an underflow. The flow checks are driven with equal tags, a higher level and a mask that is not a subset, which separates the level test from the mask test. A random mix then runs with the PC tag fed back, and the unit's outputs are compared against a bench model of the same rules.

// File: rtl/sectag_pkg.sv
package sectag_pkg;
    localparam int LVL_W   = 3;
    localparam int MASK_W  = 8;
    localparam int TAG_W   = LVL_W + MASK_W;
    localparam int CAUSE_W = 3;

    typedef struct packed {
        logic [LVL_W-1:0]  lvl;
        logic [MASK_W-1:0] mask;
    } tag_t;

    typedef enum logic [1:0] {
        IC_PLAIN  = 2'd0,
        IC_JUMP   = 2'd1,
        IC_BRCOND = 2'd2,
        IC_REJOIN = 2'd3
    } iclass_e;

    typedef enum logic [1:0] {
        CK_NONE = 2'd0,
        CK_READ = 2'd1,
        CK_OUTW = 2'd2,
        CK_INLD = 2'd3
    } chk_e;

    typedef enum logic [CAUSE_W-1:0] {
        TC_NONE = 3'd0,
        TC_READ = 3'd1,
        TC_OUTW = 3'd2,
        TC_INLD = 3'd3,
        TC_OVF  = 3'd4,
        TC_UNF  = 3'd5
    } cause_e;

    typedef struct packed {
        logic   vld;
        logic   we;
        logic   trap;
        cause_e cause;
        tag_t   res;
        tag_t   pc;
    } out_t;
endpackage

// File: rtl/sectag_join.sv
module sectag_join #(
    parameter int N = 2
) (
    input  logic [N-1:0][sectag_pkg::TAG_W-1:0] tags_i,
    output logic [sectag_pkg::TAG_W-1:0]        lub_o
);
    import sectag_pkg::*;

    tag_t acc;
    tag_t cur;

    always_comb begin
        acc = tag_t'(tags_i[0]);
        cur = acc;
        for (int k = 1; k < N; k++) begin
            cur = tag_t'(tags_i[k]);
            if (cur.lvl > acc.lvl) begin
                acc.lvl = cur.lvl;
            end
            acc.mask = acc.mask | cur.mask;
        end
    end

    assign lub_o = acc;
endmodule

// File: rtl/sectag_flow.sv
module sectag_flow (
    input  logic [sectag_pkg::TAG_W-1:0] src_i,
    input  logic [sectag_pkg::TAG_W-1:0] dst_i,
    output logic                         ok_o
);
    import sectag_pkg::*;

    tag_t src;
    tag_t dst;
    logic lvl_ok;
    logic mask_ok;

    always_comb begin
        src     = tag_t'(src_i);
        dst     = tag_t'(dst_i);
        lvl_ok  = (src.lvl <= dst.lvl);
        mask_ok = ((src.mask & ~dst.mask) == '0);
        ok_o    = lvl_ok && mask_ok;
    end
endmodule

// File: rtl/sectag_pcstack.sv
module sectag_pcstack #(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic                         pop_i,
    input  logic [sectag_pkg::TAG_W-1:0] din_i,
    output logic [sectag_pkg::TAG_W-1:0] top_o,
    output logic                         full_o,
    output logic                         empty_o
);
    import sectag_pkg::*;

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PTR_W = $clog2(DEPTH + 1);

    tag_t             mem_d [DEPTH];
    tag_t             mem_q [DEPTH];
    logic [PTR_W-1:0] cnt_d;
    logic [PTR_W-1:0] cnt_q;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] top_idx;

    always_comb begin
        full_o  = (cnt_q == PTR_W'(DEPTH));
        empty_o = (cnt_q == '0);
        wr_idx  = IDX_W'(cnt_q);
        top_idx = IDX_W'(cnt_q - 1'b1);
        top_o   = empty_o ? '0 : mem_q[top_idx];

        mem_d = mem_q;
        cnt_d = cnt_q;
        if (push_i && !full_o) begin
            mem_d[wr_idx] = tag_t'(din_i);
            cnt_d         = cnt_q + 1'b1;
        end else if (pop_i && !empty_o) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                mem_q[k] <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/sectag_unit.sv
module sectag_unit #(
    parameter int STACK_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  iclass,
    input  logic [1:0]  chk_kind,
    input  logic [10:0] op_a_tag,
    input  logic [10:0] op_b_tag,
    input  logic [10:0] insn_tag,
    input  logic [10:0] pc_tag_in,
    input  logic [10:0] principal_tag,
    output logic        out_valid,
    output logic [10:0] res_tag,
    output logic        res_we,
    output logic [10:0] pc_tag_out,
    output logic        trap,
    output logic [2:0]  trap_cause
);
    import sectag_pkg::*;

    localparam int JOIN_RES = 4;
    localparam int JOIN_BR  = 3;
    localparam int JOIN_PC  = 2;

    iclass_e          ic;
    chk_e             ck;
    logic [TAG_W-1:0] lub_res;
    logic [TAG_W-1:0] lub_br;
    logic [TAG_W-1:0] lub_pc;
    logic             a_to_prin;
    logic             a_to_chan;
    logic             stk_full;
    logic             stk_empty;
    logic [TAG_W-1:0] stk_top;
    logic             stk_push;
    logic             stk_pop;
    logic             flow_bad;
    cause_e           flow_cause;
    cause_e           cause;
    out_t             o_d;
    out_t             o_q;

    assign ic = iclass_e'(iclass);
    assign ck = chk_e'(chk_kind);

    // Tag joins for the result, the branch condition and the plain PC update
    sectag_join #(.N(JOIN_RES)) u_join_res (
        .tags_i ({op_a_tag, op_b_tag, pc_tag_in, insn_tag}),
        .lub_o  (lub_res)
    );

    sectag_join #(.N(JOIN_BR)) u_join_br (
        .tags_i ({op_a_tag, pc_tag_in, insn_tag}),
        .lub_o  (lub_br)
    );

    sectag_join #(.N(JOIN_PC)) u_join_pc (
        .tags_i ({pc_tag_in, insn_tag}),
        .lub_o  (lub_pc)
    );

    // Flow checks: datum or channel towards the principal, datum towards a channel
    sectag_flow u_flow_prin (
        .src_i (op_a_tag),
        .dst_i (principal_tag),
        .ok_o  (a_to_prin)
    );

    sectag_flow u_flow_chan (
        .src_i (op_a_tag),
        .dst_i (op_b_tag),
        .ok_o  (a_to_chan)
    );

    sectag_pcstack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (stk_push),
        .pop_i   (stk_pop),
        .din_i   (pc_tag_in),
        .top_o   (stk_top),
        .full_o  (stk_full),
        .empty_o (stk_empty)
    );

    // Trap decode: stack faults win over flow faults
    always_comb begin
        flow_bad   = 1'b0;
        flow_cause = TC_NONE;
        unique case (ck)
            CK_READ: begin
                flow_bad   = !a_to_prin;
                flow_cause = TC_READ;
            end
            CK_OUTW: begin
                flow_bad   = !a_to_chan;
                flow_cause = TC_OUTW;
            end
            CK_INLD: begin
                flow_bad   = !a_to_prin;
                flow_cause = TC_INLD;
            end
            default: begin
                flow_bad   = 1'b0;
                flow_cause = TC_NONE;
            end
        endcase

        if (ic == IC_BRCOND && stk_full) begin
            cause = TC_OVF;
        end else if (ic == IC_REJOIN && stk_empty) begin
            cause = TC_UNF;
        end else if (flow_bad) begin
            cause = flow_cause;
        end else begin
            cause = TC_NONE;
        end

        stk_push = in_valid && (ic == IC_BRCOND) && (cause == TC_NONE);
        stk_pop  = in_valid && (ic == IC_REJOIN) && (cause == TC_NONE);
    end

    // Next-state computation for the registered outputs
    always_comb begin
        o_d       = o_q;
        o_d.vld   = in_valid;
        o_d.we    = 1'b0;
        o_d.trap  = 1'b0;
        o_d.cause = TC_NONE;
        if (in_valid) begin
            o_d.trap  = (cause != TC_NONE);
            o_d.cause = cause;
            o_d.res   = tag_t'(lub_res);
            if (cause != TC_NONE) begin
                o_d.pc = tag_t'(pc_tag_in);
            end else begin
                unique case (ic)
                    IC_PLAIN:  o_d.pc = tag_t'(lub_pc);
                    IC_JUMP:   o_d.pc = tag_t'(lub_pc);
                    IC_BRCOND: o_d.pc = tag_t'(lub_br);
                    IC_REJOIN: o_d.pc = tag_t'(stk_top);
                    default:   o_d.pc = tag_t'(pc_tag_in);
                endcase
            end
            o_d.we = (ic == IC_PLAIN) && (cause == TC_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid  = o_q.vld;
    assign res_tag    = o_q.res;
    assign res_we     = o_q.we;
    assign pc_tag_out = o_q.pc;
    assign trap       = o_q.trap;
    assign trap_cause = o_q.cause;
endmodule

// File: rtl/sectag_unit_chk.sv
module sectag_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  chk_kind,
    input logic [10:0] op_a_tag,
    input logic [10:0] pc_tag_in,
    input logic [10:0] principal_tag,
    input logic        out_valid,
    input logic [10:0] res_tag,
    input logic        res_we,
    input logic [10:0] pc_tag_out,
    input logic        trap,
    input logic [2:0]  trap_cause
);
    // R12
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R12
    trap_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (!res_we && out_valid));

    // R12
    cause_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap == (trap_cause != 3'd0));

    // R1
    res_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> ((res_tag[10:8] >= $past(op_a_tag[10:8])) &&
                    (($past(op_a_tag[7:0]) & ~res_tag[7:0]) == 8'd0)));

    // R10
    stk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && (trap_cause == 3'd4 || trap_cause == 3'd5)) |->
            (pc_tag_out == $past(pc_tag_in)));

    // R7
    read_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && trap_cause == 3'd1) |->
            ($past(chk_kind) == 2'd1 &&
             (($past(op_a_tag[10:8]) > $past(principal_tag[10:8])) ||
              (($past(op_a_tag[7:0]) & ~$past(principal_tag[7:0])) != 8'd0))));
endmodule

bind sectag_unit sectag_unit_chk chk_i (.*);

// File: tb/sectag_unit_test.sv
`timescale 1ns/1ps
module sectag_unit_test;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  iclass = 2'd0;
    logic [1:0]  chk_kind = 2'd0;
    logic [10:0] op_a_tag = '0;
    logic [10:0] op_b_tag = '0;
    logic [10:0] insn_tag = '0;
    logic [10:0] pc_tag_in = '0;
    logic [10:0] principal_tag = '0;
    logic        out_valid;
    logic [10:0] res_tag;
    logic        res_we;
    logic [10:0] pc_tag_out;
    logic        trap;
    logic [2:0]  trap_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [10:0] stk_m [DEPTH];
    int          depth_m = 0;
    logic [10:0] pc_m = '0;

    always #10 clk = ~clk;

    sectag_unit #(.STACK_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .iclass(iclass),
        .chk_kind(chk_kind), .op_a_tag(op_a_tag), .op_b_tag(op_b_tag),
        .insn_tag(insn_tag), .pc_tag_in(pc_tag_in), .principal_tag(principal_tag),
        .out_valid(out_valid), .res_tag(res_tag), .res_we(res_we),
        .pc_tag_out(pc_tag_out), .trap(trap), .trap_cause(trap_cause)
    );

    // R6 join and flow rules
    function automatic logic [10:0] jn(input logic [10:0] x, input logic [10:0] y);
        logic [2:0] l;
        l = (x[10:8] > y[10:8]) ? x[10:8] : y[10:8];
        return {l, x[7:0] | y[7:0]};
    endfunction

    function automatic bit flows(input logic [10:0] s, input logic [10:0] d);
        return (s[10:8] <= d[10:8]) && ((s[7:0] & ~d[7:0]) == 8'd0);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] ic, input logic [1:0] ck,
                        input logic [10:0] a, input logic [10:0] b,
                        input logic [10:0] i, input logic [10:0] p,
                        input string req);
        logic [2:0]  ecause;
        logic        etrap;
        logic        ewe;
        logic [10:0] epc;
        logic [10:0] eres;
        if (ic == 2'd2 && depth_m == DEPTH)      ecause = 3'd4;
        else if (ic == 2'd3 && depth_m == 0)     ecause = 3'd5;
        else if (ck == 2'd1 && !flows(a, p))     ecause = 3'd1;
        else if (ck == 2'd2 && !flows(a, b))     ecause = 3'd2;
        else if (ck == 2'd3 && !flows(a, p))     ecause = 3'd3;
        else                                     ecause = 3'd0;
        etrap = (ecause != 3'd0);
        eres  = jn(jn(a, b), jn(pc_m, i));
        if (etrap)            epc = pc_m;
        else if (ic == 2'd2)  epc = jn(a, jn(pc_m, i));
        else if (ic == 2'd3)  epc = stk_m[depth_m-1];
        else                  epc = jn(pc_m, i);
        ewe = (ic == 2'd0) && !etrap;

        @(negedge clk);
        in_valid = 1'b1; iclass = ic; chk_kind = ck;
        op_a_tag = a; op_b_tag = b; insn_tag = i;
        principal_tag = p; pc_tag_in = pc_m;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R12", "out_valid", int'(out_valid), 1);
        chk(trap == etrap, req, "trap", int'(trap), int'(etrap));
        chk(trap_cause == ecause, req, "trap_cause", int'(trap_cause), int'(ecause));
        chk(res_we == ewe, req, "res_we", int'(res_we), int'(ewe));
        chk(pc_tag_out == epc, req, "pc_tag_out", int'(pc_tag_out), int'(epc));
        if (ewe) chk(res_tag == eres, req, "res_tag", int'(res_tag), int'(eres));

        if (!etrap && ic == 2'd2) begin
            stk_m[depth_m] = pc_m;
            depth_m++;
        end else if (!etrap && ic == 2'd3) begin
            depth_m--;
        end
        pc_m = epc;
    endtask

    function automatic logic [10:0] rtag();
        return {3'($urandom % 8), 8'($urandom & $urandom)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R12 watchdog: actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(out_valid == 1'b0, "R12", "reset out_valid", int'(out_valid), 0);
        chk(trap == 1'b0, "R12", "reset trap", int'(trap), 0);
        chk(res_we == 1'b0, "R12", "reset res_we", int'(res_we), 0);

        // R11 rejoin on empty stack right after reset
        step(2'd3, 2'd0, 11'h000, 11'h000, 11'h000, 11'h000, "R11");

        // R1 R2 R6 plain instruction join
        step(2'd0, 2'd0, {3'd2, 8'h01}, {3'd5, 8'h10}, {3'd1, 8'h80}, 11'h000, "R1");
        chk(res_tag == {3'd5, 8'h91}, "R6", "res_tag join", int'(res_tag), int'({3'd5, 8'h91}));
        chk(pc_tag_out == {3'd1, 8'h80}, "R2", "pc join", int'(pc_tag_out), int'({3'd1, 8'h80}));

        // R3 unconditional branch
        step(2'd1, 2'd0, {3'd7, 8'hFF}, 11'h000, {3'd2, 8'h04}, 11'h000, "R3");

        // R4 R5 nested branches restore in LIFO order
        step(2'd2, 2'd0, {3'd3, 8'h02}, 11'h000, 11'h000, 11'h000, "R4");
        step(2'd2, 2'd0, {3'd6, 8'h40}, 11'h000, 11'h000, 11'h000, "R4");
        step(2'd3, 2'd0, 11'h000, 11'h000, 11'h000, 11'h000, "R5");
        step(2'd3, 2'd0, 11'h000, 11'h000, 11'h000, 11'h000, "R5");
        chk(pc_tag_out == {3'd2, 8'h84}, "R5", "outer restore", int'(pc_tag_out), int'({3'd2, 8'h84}));

        // R10 fill the stack, then overflow
        for (int k = 0; k < DEPTH; k++)
            step(2'd2, 2'd0, {3'(k), 8'(1 << k)}, 11'h000, 11'h000, 11'h000, "R4");
        step(2'd2, 2'd0, {3'd7, 8'hFF}, 11'h000, 11'h000, 11'h000, "R10");
        // R12 stack fault wins over a denied read
        step(2'd2, 2'd1, {3'd7, 8'hFF}, 11'h000, 11'h000, 11'h000, "R12");
        for (int k = 0; k < DEPTH; k++)
            step(2'd3, 2'd0, 11'h000, 11'h000, 11'h000, 11'h000, "R5");
        step(2'd3, 2'd0, 11'h000, 11'h000, 11'h000, 11'h000, "R11");

        // R7 read: equal allowed, higher level denied, mask not subset denied
        step(2'd0, 2'd1, {3'd3, 8'h0F}, 11'h000, 11'h000, {3'd3, 8'h0F}, "R7");
        step(2'd0, 2'd1, {3'd4, 8'h01}, 11'h000, 11'h000, {3'd3, 8'hFF}, "R7");
        step(2'd0, 2'd1, {3'd1, 8'h30}, 11'h000, 11'h000, {3'd7, 8'h10}, "R7");
        // R8 output write towards the channel in op_b
        step(2'd0, 2'd2, {3'd2, 8'h03}, {3'd2, 8'h07}, 11'h000, 11'h000, "R8");
        step(2'd0, 2'd2, {3'd2, 8'h08}, {3'd5, 8'h07}, 11'h000, 11'h7FF, "R8");
        // R9 input load from the channel in op_a
        step(2'd0, 2'd3, {3'd1, 8'h01}, 11'h000, 11'h000, {3'd2, 8'h01}, "R9");
        step(2'd0, 2'd3, {3'd6, 8'h01}, 11'h000, 11'h000, {3'd2, 8'hFF}, "R9");
        step(2'd0, 2'd0, 11'h7FF, 11'h7FF, 11'h000, 11'h000, "R9");

        // R12 idle cycle
        @(negedge clk);
        chk(out_valid == 1'b0, "R12", "idle out_valid", int'(out_valid), 0);
        chk(trap == 1'b0, "R12", "idle trap", int'(trap), 0);

        // Random mix with PC tag feedback
        for (int n = 0; n < 800; n++) begin
            logic [10:0] a;
            logic [10:0] b;
            logic [10:0] p;
            a = rtag();
            b = rtag();
            p = rtag();
            if ($urandom % 2 == 0) p = jn(p, a);
            if ($urandom % 2 == 0) b = jn(b, a);
            if (n % 97 == 0) pc_m = 11'h000;
            step(2'($urandom % 4), 2'($urandom % 4), a, b, 11'($urandom & 11'h10F), p, "R1");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule